// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the eleven interrupt sources of a UART into one set of sticky raw status bits. Four of the sources come from the modem-control lines: each line is brought into the clock domain through a two-stage synchronizer, and any change of level, up or down, sets that line's own status bit. The other seven sources are single-cycle event pulses. Three come from the receive, transmit-level and receive-timeout logic. Four come from the receive error detectors: framing, parity, break and overrun.

Software controls the block through a small synchronous register port. One address holds the per-source enable mask, which is read and written as a whole word, one bit per source. A second address reads the raw bits before masking. A third reads the masked bits, which are the raw bits ANDed with the mask. A fourth address takes write-one-to-clear writes. The single interrupt output is high whenever any masked bit is high. Read data is combinational from the address.

Bit map of the status, mask and clear words: bit 0 RI change, bit 1 CTS change, bit 2 DCD change, bit 3 DSR change, bit 4 receive, bit 5 transmit, bit 6 receive timeout, bit 7 framing error, bit 8 parity error, bit 9 break error, bit 10 overrun error. Register addresses: 0 mask, 1 raw status, 2 masked status, 3 clear.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a reset cycle, every raw bit and every mask bit is 0 and `irq` is low.
- R2: A write to address 0 loads mask bits 10..0 from `reg_wdata[10:0]`, one bit per source. Reading address 0 returns the mask, and bits 15..11 of any read are 0.
- R3: `irq` is high exactly when at least one bit of (raw AND mask) is 1.
- R4: Address 1 returns the raw bits whatever the mask holds. Address 2 returns raw AND mask.
- R5: A change of level on `modem_ri_n`, `modem_cts_n`, `modem_dcd_n` or `modem_dsr_n`, rising or falling, sets raw bit 0, 1, 2 or 3 respectively. The bit reads 1 after the second clock edge following the edge that first samples the new level.
- R6: A high pulse on `rx_evt`, `tx_evt`, `rto_evt`, `err_frame`, `err_parity`, `err_break` or `err_overrun` at a clock edge sets raw bit 4, 5, 6, 7, 8, 9 or 10 at that edge. The bit stays set after the pulse ends.
- R7: A write to address 3 clears each raw bit whose `reg_wdata` bit is 1. Bits written 0 keep their value, and a raw bit never falls except through such a write or reset.
- R8: Each of the error bits 7, 8, 9 and 10 is cleared by its own clear bit alone, leaving the other error bits set.
- R9: When a set event and a clear write hit the same bit at the same edge, the bit ends up set.
- R10: Writes to addresses 1, 2 and 4..7 change neither raw nor mask bits. Reads of addresses 3 and 4..7 return 0.
- R11: The synchronizers reset to the idle high level, so lines held high through and after reset raise no modem bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modem_ri_n | input | 1 | Ring indicator line, asynchronous |
| modem_cts_n | input | 1 | Clear-to-send line, asynchronous |
| modem_dcd_n | input | 1 | Carrier detect line, asynchronous |
| modem_dsr_n | input | 1 | Data-set-ready line, asynchronous |
| rx_evt | input | 1 | Receive level event pulse |
| tx_evt | input | 1 | Transmit level event pulse |
| rto_evt | input | 1 | Receive timeout event pulse |
| err_frame | input | 1 | Framing error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_break | input | 1 | Break error pulse |
| err_overrun | input | 1 | Overrun error pulse |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | DATA_W (16) | Register read data, combinational from address |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a set and a clear landing on the same bit at the same edge. For the modem bits, the set lands two edges after the line is first sampled, so the clear write has to be timed against the synchronizer delay rather than against the line change. The bench reaches it directly for the pulse sources by driving the pulse and the clear write together. It reaches it for the modem bits through a long pseudo-random phase in which line toggles, pulses, clears and mask writes overlap freely. A behavioural model that keeps a history queue of sampled line levels predicts every read and the interrupt line on every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC   = 11;
    localparam int NUM_MODEM = 4;
    localparam int NUM_PULSE = NUM_SRC - NUM_MODEM;

    // source positions; the clear and mask words share this map
    localparam int IDX_RI      = 0;
    localparam int IDX_CTS     = 1;
    localparam int IDX_DCD     = 2;
    localparam int IDX_DSR     = 3;
    localparam int IDX_RX      = 4;
    localparam int IDX_TX      = 5;
    localparam int IDX_RTO     = 6;
    localparam int IDX_FRAME   = 7;
    localparam int IDX_PARITY  = 8;
    localparam int IDX_BREAK   = 9;
    localparam int IDX_OVERRUN = 10;

    // register addresses
    localparam int REG_MASK   = 0;
    localparam int REG_RAW    = 1;
    localparam int REG_MASKED = 2;
    localparam int REG_CLEAR  = 3;

    typedef logic [NUM_SRC-1:0]   src_vec_t;
    typedef logic [NUM_MODEM-1:0] modem_vec_t;
    typedef logic [NUM_PULSE-1:0] pulse_vec_t;

    typedef struct packed {
        logic     mask_we;
        logic     clr_we;
        src_vec_t data;
    } wr_cmd_t;

    // pulse vector bit 0 is the receive event, so it lands at IDX_RX
    function automatic src_vec_t merge_events(modem_vec_t chg, pulse_vec_t pls);
        return {pls, chg};
    endfunction

    // set has priority over clear
    function automatic src_vec_t next_raw(src_vec_t cur, src_vec_t set, src_vec_t clr);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/uart_irq_modem_sync.sv
module uart_irq_modem_sync #(
    parameter int   NUM_LINES  = 4,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_async,
    output logic [NUM_LINES-1:0] changed
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= IDLE_LEVEL;
                sync_q <= IDLE_LEVEL;
                prev_q <= IDLE_LEVEL;
            end else begin
                meta_q <= lines_async[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign changed[g] = sync_q ^ prev_q;
    end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  wr_cmd_t  wr_cmd,
    output src_vec_t raw_q,
    output src_vec_t mask_q,
    output src_vec_t clr_vec
);

    assign clr_vec = wr_cmd.clr_we ? wr_cmd.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= next_raw(raw_q, set_vec, clr_vec);
            if (wr_cmd.mask_we) begin
                mask_q <= wr_cmd.data;
            end
        end
    end

endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  src_vec_t          raw_q,
    input  src_vec_t          mask_q,
    output wr_cmd_t           wr_cmd,
    output src_vec_t          masked,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    assign masked = raw_q & mask_q;

    always_comb begin
        wr_cmd.mask_we = reg_we && (reg_addr == ADDR_W'(REG_MASK));
        wr_cmd.clr_we  = reg_we && (reg_addr == ADDR_W'(REG_CLEAR));
        wr_cmd.data    = reg_wdata[NUM_SRC-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(REG_MASK):   reg_rdata = {{PAD_W{1'b0}}, mask_q};
            ADDR_W'(REG_RAW):    reg_rdata = {{PAD_W{1'b0}}, raw_q};
            ADDR_W'(REG_MASKED): reg_rdata = {{PAD_W{1'b0}}, masked};
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              modem_ri_n,
    input  logic              modem_cts_n,
    input  logic              modem_dcd_n,
    input  logic              modem_dsr_n,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              rto_evt,
    input  logic              err_frame,
    input  logic              err_parity,
    input  logic              err_break,
    input  logic              err_overrun,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    modem_vec_t modem_lines;
    modem_vec_t modem_chg;
    pulse_vec_t pulses;
    src_vec_t   set_vec;
    src_vec_t   clr_vec;
    src_vec_t   raw_q;
    src_vec_t   mask_q;
    src_vec_t   masked;
    wr_cmd_t    wr_cmd;

    always_comb begin
        modem_lines              = '0;
        modem_lines[IDX_RI]      = modem_ri_n;
        modem_lines[IDX_CTS]     = modem_cts_n;
        modem_lines[IDX_DCD]     = modem_dcd_n;
        modem_lines[IDX_DSR]     = modem_dsr_n;
        pulses                   = {err_overrun, err_break, err_parity, err_frame,
                                    rto_evt, tx_evt, rx_evt};
    end

    uart_irq_modem_sync #(
        .NUM_LINES (NUM_MODEM),
        .IDLE_LEVEL(1'b1)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .lines_async(modem_lines),
        .changed    (modem_chg)
    );

    assign set_vec = merge_events(modem_chg, pulses);

    uart_irq_status u_status (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .wr_cmd (wr_cmd),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .clr_vec(clr_vec)
    );

    uart_irq_regif #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regif (
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .wr_cmd   (wr_cmd),
        .masked   (masked),
        .reg_rdata(reg_rdata)
    );

    assign irq = |masked;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] reg_addr,
    input src_vec_t          raw_q,
    input src_vec_t          mask_q,
    input src_vec_t          set_vec,
    input src_vec_t          clr_vec
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && mask_q == '0 && !irq)); // R1

    AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:NUM_SRC] == '0); // R2

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw_q != '0 && mask_q != '0)); // R3

    AST_RAW_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~raw_q & $past(raw_q) & ~$past(clr_vec)) == '0)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec))); // R9

    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > ADDR_W'(REG_MASKED)) |-> (reg_rdata == '0)); // R10

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .reg_rdata(reg_rdata),
    .reg_addr (reg_addr),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        modem_n = 4'hF;   // {dsr, dcd, cts, ri}
    logic [6:0]        pulses = '0;      // {ovr, brk, par, frm, rto, tx, rx}
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    always #2 clk = ~clk;

    uart_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .modem_ri_n(modem_n[0]), .modem_cts_n(modem_n[1]),
        .modem_dcd_n(modem_n[2]), .modem_dsr_n(modem_n[3]),
        .rx_evt(pulses[0]), .tx_evt(pulses[1]), .rto_evt(pulses[2]),
        .err_frame(pulses[3]), .err_parity(pulses[4]),
        .err_break(pulses[5]), .err_overrun(pulses[6]),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model
    logic [10:0] m_raw  = '0;
    logic [10:0] m_mask = '0;
    logic [3:0]  hist[$];

    always @(posedge clk) begin
        logic [10:0] set_bits;
        logic [10:0] clr_bits;
        if (rst) begin
            m_raw  = '0;
            m_mask = '0;
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back(4'hF);
        end else begin
            hist.push_back(modem_n);
            if (hist.size() > 4) void'(hist.pop_front());
            set_bits = {pulses, hist[1] ^ hist[0]};
            clr_bits = (reg_we && reg_addr == 3) ? reg_wdata[10:0] : '0;
            m_raw = (m_raw & ~clr_bits) | set_bits;
            if (reg_we && reg_addr == 0) m_mask = reg_wdata[10:0];
        end
    end

    always @(negedge clk) begin
        logic [DATA_W-1:0] exp_rd;
        logic              exp_irq;
        if (!rst) begin
            case (reg_addr)
                3'd0:    exp_rd = {5'b0, m_mask};
                3'd1:    exp_rd = {5'b0, m_raw};
                3'd2:    exp_rd = {5'b0, m_raw & m_mask};
                default: exp_rd = '0;
            endcase
            exp_irq = |(m_raw & m_mask);
            n_cmp++;
            if (reg_rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rdata addr=%0d actual=%h expected=%h",
                         cur_req, reg_addr, reg_rdata, exp_rd);
            end
            n_cmp++;
            if (irq !== exp_irq) begin
                n_bad++;
                $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_irq);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        idle(1);
        reg_we    = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] p);
        pulses = p;
        idle(1);
        pulses = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        reg_addr = a;
        idle(1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lf;
        idle(3);
        rst = 1'b0;

        // R1 / R11: quiet after reset, lines idle high
        cur_req = "R1";
        for (int a = 0; a < 4; a++) rd(3'(a));
        cur_req = "R11";
        idle(4);
        rd(3'd1);

        // R2: mask write, readback, upper bits zero
        cur_req = "R2";
        wr(3'd0, 16'h0555);
        rd(3'd0);
        wr(3'd0, 16'hFFFF);
        rd(3'd0);

        // R6 / R3: pulse sources set sticky bits and drive irq
        cur_req = "R6";
        reg_addr = 3'd1;
        pulse(7'b0000001);
        idle(2);
        pulse(7'b0000110);
        idle(1);
        cur_req = "R3";
        wr(3'd0, 16'h0000);
        rd(3'd2);
        wr(3'd0, 16'h0020);
        rd(3'd2);

        // R4: raw view ignores mask
        cur_req = "R4";
        rd(3'd1);
        wr(3'd0, 16'h0000);
        rd(3'd1);
        rd(3'd2);
        wr(3'd0, 16'h07FF);

        // R7: clear with zeros, then clear selected ones
        cur_req = "R7";
        wr(3'd3, 16'h0000);
        rd(3'd1);
        wr(3'd3, 16'h0010);
        rd(3'd1);
        wr(3'd3, 16'hFFFF);
        rd(3'd1);

        // R5: each modem line, falling then rising
        cur_req = "R5";
        for (int l = 0; l < 4; l++) begin
            reg_addr = 3'd1;
            modem_n[l] = 1'b0;
            idle(4);
            wr(3'd3, 16'h000F);
            reg_addr = 3'd1;
            modem_n[l] = 1'b1;
            idle(1);
            rd(3'd1);
            rd(3'd1);
            idle(2);
            wr(3'd3, 16'h000F);
        end

        // R8: error bits cleared one at a time
        cur_req = "R8";
        pulse(7'b1111000);
        for (int b = 7; b < 11; b++) begin
            wr(3'd3, 16'(1 << b));
            rd(3'd1);
        end

        // R9: set and clear collide on the same bit
        cur_req = "R9";
        pulses = 7'b0100100;
        wr(3'd3, 16'h0240);
        pulses = '0;
        rd(3'd1);
        wr(3'd3, 16'h07FF);

        // R10: writes to non-writable addresses, reads of empty ones
        cur_req = "R10";
        pulse(7'b0000011);
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        wr(3'd5, 16'h0000);
        wr(3'd7, 16'hFFFF);
        rd(3'd0);
        rd(3'd1);
        rd(3'd3);
        rd(3'd4);
        rd(3'd6);

        // mixed traffic: overlapping toggles, pulses, clears, mask writes
        cur_req = "R5";
        lf = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] == 4'h0) modem_n[lf[5:4]] = ~modem_n[lf[5:4]];
            pulses    = (lf[8:6] == 3'b000) ? lf[15:9] : 7'b0;
            reg_addr  = lf[18:16];
            reg_wdata = lf[31:16];
            reg_we    = lf[20:19] == 2'b00;
            cur_req   = reg_we ? ((reg_addr == 3'd3) ? "R9" : "R2") : "R5";
            idle(1);
        end
        reg_we = 1'b0;
        pulses = '0;
        idle(4);

        summary();
        $finish;
    end

endmodule